// File: doc/BRIEF.md
# Real-Time Clock Register Block with Sequenced Shadow Copies

This block is the bus-facing register file of a real-time clock. A simple 32-bit register bus writes and reads a control word, a status word, a seconds value, an alarm value, a watchdog timeout and a set of persistent configuration words. The bus addresses whole words. Each writable word can be written plainly or through three alias addresses that set, clear or toggle only the bits written as 1. This gives software single-access read-modify-write.

Seconds, alarm and persistent words do not take effect at once. Each write is copied into an always-on copy domain, one word at a time, in a fixed priority order. Each copy takes a parameterised number of clock cycles. A per-word stale flag in the status word shows which copies are still outstanding. The always-on side keeps the live seconds count, which advances on a 1 Hz enable. It compares that count with the copied alarm value to raise an alarm flag and an interrupt. A watchdog down-counter, clocked by a millisecond enable, produces a one-cycle reset request.

Top module: `rtc_regblock`

## Requirements
- R1: After reset, CTRL reads 0, SECONDS reads 0, all stale flags are 0, and STAT bit 31 reads 1. STAT bit 28 mirrors `xtal_32000_in` and bit 27 mirrors `xtal_32768_in`.
- R2: The word address is {register index[5:2], operation[1:0]}. Register indices are CTRL 0, STAT 1, SECONDS 3, ALARM 4, WATCHDOG 5 and PERSISTENT n at 6+n. Operation 0 writes the data, 1 ORs it in, 2 clears the bits written as 1 and 3 inverts them. CTRL keeps only bits 0, 1, 2 and 4. Reads ignore the operation bits.
- R3: A write to PERSISTENT n, ALARM or SECONDS sets stale flag n, 6 or 7 respectively (STAT bits 16+n, 22, 23) at the same clock edge.
- R4: Copies run one at a time. An idle sequencer starts the lowest-numbered stale flag, and a running copy completes before another starts. A flag clears COPY_CYCLES cycles after its copy starts, so it clears COPY_CYCLES+1 cycles after a write to an idle sequencer.
- R5: A write to the word whose copy is running restarts that copy's cycle count without touching other pending copies.
- R6: The live seconds count, read at SECONDS, increments on each `sec_tick`. A written seconds value replaces it only when that copy completes.
- R7: When live seconds first equal the copied alarm value while copied PERSISTENT0 bit 2 is 1, CTRL bit 2 sets. `alarm_irq` equals CTRL bit 2 AND CTRL bit 0. A clear-alias write removes the flag, and the flag does not set again while the match persists.
- R8: On that alarm event, if copied PERSISTENT0 bit 1 is 1, PERSISTENT0 bit 7 sets.
- R9: `ms_irq` equals `ms_tick` AND CTRL bit 1.
- R10: With CTRL bit 4 at 1 and a nonzero WATCHDOG value T, `wdog_rst` pulses for one cycle after the T-th `ms_tick`, and the count then reloads with T. A WATCHDOG value of 0 produces no pulse.
- R11: A write that leaves PERSISTENT1 bit 31 at 1 marks every persistent copy stale.
- R12: Writes to STAT and to unmapped indices change nothing, and unmapped indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_waddr | input | 6 | Word address: register index and alias operation |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr` (combinational) |
| sec_tick | input | 1 | 1 Hz enable, one cycle wide |
| ms_tick | input | 1 | Millisecond enable, one cycle wide |
| xtal_32000_in | input | 1 | 32000 Hz crystal present |
| xtal_32768_in | input | 1 | 32768 Hz crystal present |
| alarm_irq | output | 1 | Alarm interrupt |
| ms_irq | output | 1 | Millisecond interrupt |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The copy sequencer is exercised with three write patterns.
- A lone seconds write to an idle sequencer fixes the exact completion latency.
- Four writes landing while the seconds copy is busy show that the order follows the priority order rather than arrival order: PERSISTENT0 completes before PERSISTENT1, and both complete before ALARM.
- A second write to the word being copied shows a restart, because completion moves by exactly the cycles elapsed.

The alarm is tested by approaching the match one tick at a time, then clearing the flag while the match still holds. The watchdog is run through two full timeouts to show that it reloads, and is then disabled with a zero timeout.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int DW          = 32;
  localparam int STALE_SLOTS = 8;
  localparam int STALE_ALM   = 6;
  localparam int STALE_SEC   = 7;
  localparam int PERS_BASE   = 6;

  localparam logic [3:0] IDX_CTRL = 4'd0;
  localparam logic [3:0] IDX_STAT = 4'd1;
  localparam logic [3:0] IDX_SEC  = 4'd3;
  localparam logic [3:0] IDX_ALM  = 4'd4;
  localparam logic [3:0] IDX_WD   = 4'd5;

  localparam int CB_ALM_IE  = 0;
  localparam int CB_MS_IE   = 1;
  localparam int CB_ALM_FLG = 2;
  localparam int CB_WD_EN   = 4;
  localparam logic [DW-1:0] CTRL_MASK = 32'h0000_0017;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  function automatic logic [DW-1:0] apply_op(alias_op_e op, logic [DW-1:0] cur,
                                             logic [DW-1:0] data);
    case (op)
      OP_SET:  return cur | data;
      OP_CLR:  return cur & ~data;
      OP_TOG:  return cur ^ data;
      default: return data;
    endcase
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
`timescale 1ns/1ps
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_shadow_seq.sv
`timescale 1ns/1ps
module rtc_shadow_seq #(
  parameter int SLOTS       = 8,
  parameter int COPY_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOTS-1:0]         set_stale,
  output logic [SLOTS-1:0]         stale,
  output logic                     commit,
  output logic [$clog2(SLOTS)-1:0] commit_idx
);
  localparam int IW = $clog2(SLOTS);
  localparam int CW = (COPY_CYCLES > 1) ? $clog2(COPY_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(COPY_CYCLES - 1);

  logic [SLOTS-1:0] stale_q, stale_d;
  logic             active_q, active_d;
  logic [IW-1:0]    idx_q, idx_d, pick;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             start, restart, done;

  always_comb begin
    pick = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (stale_q[k]) pick = IW'(k);
    end
    start   = !active_q && (|stale_q);
    restart = active_q && set_stale[idx_q];
    done    = active_q && !restart && (cnt_q == CNT_LAST);

    stale_d = stale_q | set_stale;
    if (done) stale_d[idx_q] = 1'b0;

    active_d = active_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    if (start) begin
      active_d = 1'b1;
      idx_d    = pick;
      cnt_d    = '0;
    end else if (done) begin
      active_d = 1'b0;
    end else if (restart) begin
      cnt_d = '0;
    end else if (active_q) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_q  <= '0;
      active_q <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
    end else begin
      stale_q  <= stale_d;
      active_q <= active_d;
      if (start) idx_q <= idx_d;
      if (start || active_q) cnt_q <= cnt_d;
    end
  end

  assign stale      = stale_q;
  assign commit     = done;
  assign commit_idx = idx_q;

  logic [SLOTS-1:0] below_idx;
  assign below_idx = (SLOTS'(1) << idx_q) - SLOTS'(1);

  // R4: the running copy always belongs to a stale word
  p_active_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> stale_q[idx_q]);
  // R4: at most one stale flag clears per cycle
  p_one_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(stale_q) & ~stale_q) <= 1);
  // R4: a starting copy had no lower-numbered stale word pending
  p_lowest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> (($past(stale_q) & below_idx) == '0));
endmodule

// File: rtl/rtc_wdog.sv
`timescale 1ns/1ps
module rtc_wdog #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         load,
  input  logic [W-1:0] timeout,
  input  logic         tick,
  output logic         fire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         fire_q, fire_d;
  logic         armed;

  always_comb begin
    armed  = enable && (timeout != '0);
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (load || !armed) begin
      cnt_d = timeout;
    end else if (tick) begin
      if (cnt_q <= W'(1)) begin
        fire_d = 1'b1;
        cnt_d  = timeout;
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;

  // R10: a reset pulse only follows a tick seen while enabled
  p_fire_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> ($past(tick) && $past(enable)));
endmodule

// File: rtl/rtc_regblock.sv
`timescale 1ns/1ps
module rtc_regblock
  import rtc_pkg::*;
#(
  parameter int COPY_CYCLES = 4,
  parameter int NUM_PERS    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [5:0]    bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sec_tick,
  input  logic          ms_tick,
  input  logic          xtal_32000_in,
  input  logic          xtal_32768_in,
  output logic          alarm_irq,
  output logic          ms_irq,
  output logic          wdog_rst
);
  localparam int IW = $clog2(STALE_SLOTS);

  logic            rst_i_n;
  logic [3:0]      reg_idx;
  alias_op_e       op;
  logic            wr_ctrl, wr_sec, wr_alm, wr_wd;
  logic [NUM_PERS-1:0]         wr_pers;
  logic [DW-1:0]   ctrl_q, ctrl_d, sec_wr_q, sec_wr_d, alm_q, alm_d, wd_q, wd_d;
  logic [NUM_PERS-1:0][DW-1:0] pers_q, pers_d;
  logic [STALE_SLOTS-1:0]      set_stale, stale;
  logic            commit;
  logic [IW-1:0]   commit_idx;
  logic            commit_sec, commit_alm, commit_p0;
  logic [DW-1:0]   live_sec_q, live_sec_d, sh_alm_q;
  logic [1:0]      sh_p0_q;
  logic            match, match_q, alarm_hit;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i_n));

  assign reg_idx = bus_waddr[5:2];
  assign op      = alias_op_e'(bus_waddr[1:0]);

  // decode and bus-side next state
  always_comb begin
    wr_ctrl = bus_we && (reg_idx == IDX_CTRL);
    wr_sec  = bus_we && (reg_idx == IDX_SEC);
    wr_alm  = bus_we && (reg_idx == IDX_ALM);
    wr_wd   = bus_we && (reg_idx == IDX_WD);

    ctrl_d   = wr_ctrl ? (apply_op(op, ctrl_q, bus_wdata) & CTRL_MASK) : ctrl_q;
    sec_wr_d = wr_sec ? apply_op(op, sec_wr_q, bus_wdata) : sec_wr_q;
    alm_d    = wr_alm ? apply_op(op, alm_q, bus_wdata) : alm_q;
    wd_d     = wr_wd  ? apply_op(op, wd_q, bus_wdata)  : wd_q;
    if (alarm_hit) ctrl_d[CB_ALM_FLG] = 1'b1;

    for (int i = 0; i < NUM_PERS; i++) begin
      wr_pers[i] = bus_we && (reg_idx == 4'(PERS_BASE + i));
      pers_d[i]  = wr_pers[i] ? apply_op(op, pers_q[i], bus_wdata) : pers_q[i];
    end
    if (alarm_hit && sh_p0_q[0]) pers_d[0][7] = 1'b1;

    set_stale = '0;
    set_stale[NUM_PERS-1:0] = wr_pers;
    if (wr_pers[1] && pers_d[1][31]) set_stale[NUM_PERS-1:0] = '1;
    set_stale[STALE_ALM] = wr_alm;
    set_stale[STALE_SEC] = wr_sec;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q   <= '0;
      sec_wr_q <= '0;
      alm_q    <= '0;
      wd_q     <= '0;
      pers_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      pers_q <= pers_d;
      if (wr_sec) sec_wr_q <= sec_wr_d;
      if (wr_alm) alm_q    <= alm_d;
      if (wr_wd)  wd_q     <= wd_d;
    end
  end

  rtc_shadow_seq #(.SLOTS(STALE_SLOTS), .COPY_CYCLES(COPY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .set_stale(set_stale), .stale(stale),
    .commit(commit), .commit_idx(commit_idx));

  // always-on copy domain
  always_comb begin
    commit_sec = commit && (commit_idx == IW'(STALE_SEC));
    commit_alm = commit && (commit_idx == IW'(STALE_ALM));
    commit_p0  = commit && (commit_idx == '0);
    live_sec_d = live_sec_q;
    if (commit_sec)    live_sec_d = sec_wr_q;
    else if (sec_tick) live_sec_d = live_sec_q + 32'd1;
    match     = sh_p0_q[1] && (live_sec_q == sh_alm_q);
    alarm_hit = match && !match_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      live_sec_q <= '0;
      sh_alm_q   <= '0;
      sh_p0_q    <= '0;
      match_q    <= 1'b0;
    end else begin
      live_sec_q <= live_sec_d;
      match_q    <= match;
      if (commit_alm) sh_alm_q <= alm_q;
      if (commit_p0)  sh_p0_q  <= pers_q[0][2:1];
    end
  end

  rtc_wdog #(.W(DW)) u_wd (
    .clk(clk), .rst_n(rst_i_n), .enable(ctrl_q[CB_WD_EN]), .load(wr_wd),
    .timeout(wd_d), .tick(ms_tick), .fire(wdog_rst));

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (reg_idx)
      IDX_CTRL: bus_rdata = ctrl_q;
      IDX_STAT: bus_rdata = {1'b1, 2'b00, xtal_32000_in, xtal_32768_in, 3'b000,
                             stale, 16'h0000};
      IDX_SEC:  bus_rdata = live_sec_q;
      IDX_ALM:  bus_rdata = alm_q;
      IDX_WD:   bus_rdata = wd_q;
      default: begin
        for (int i = 0; i < NUM_PERS; i++) begin
          if (reg_idx == 4'(PERS_BASE + i)) bus_rdata = pers_q[i];
        end
      end
    endcase
  end

  assign alarm_irq = ctrl_q[CB_ALM_FLG] && ctrl_q[CB_ALM_IE];
  assign ms_irq    = ms_tick && ctrl_q[CB_MS_IE];

  // R3: seconds and alarm writes leave their stale flags set
  p_stale_sec_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_sec |=> stale[STALE_SEC]);
  p_stale_alm_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_alm |=> stale[STALE_ALM]);
  // R6: live seconds hold without a tick or a completed copy
  p_sec_hold_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sec_tick && !commit_sec) |=> $stable(live_sec_q));
  // R7: the alarm flag rises only from a match or a control write
  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(ctrl_q[CB_ALM_FLG]) |-> $past(alarm_hit || wr_ctrl));
endmodule

// File: tb/sim_rtc_regblock.sv
`timescale 1ns/1ps
module sim_rtc_regblock;
  logic        clk = 1'b0;
  logic        rst_n, bus_we, sec_tick, ms_tick, xtal_32000_in, xtal_32768_in;
  logic [5:0]  bus_waddr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        alarm_irq, ms_irq, wdog_rst;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  event     mon_ev;

  always #10 clk = ~clk;

  rtc_regblock u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .ms_tick(ms_tick), .xtal_32000_in(xtal_32000_in),
    .xtal_32768_in(xtal_32768_in), .alarm_irq(alarm_irq), .ms_irq(ms_irq),
    .wdog_rst(wdog_rst));

  // monitor: pops the expected read and compares
  initial begin
    forever begin
      @(mon_ev);
      if (sb_q.size() != 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (bus_rdata !== it.exp) begin
          n_errors++;
          $display("FAIL %s: read %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] stat_exp(logic [7:0] stl, logic x32k, logic x32768);
    return {1'b1, 2'b00, x32k, x32768, 3'b000, stl, 16'h0000};
  endfunction

  task automatic exp_rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
    sb_item_t it;
    bus_waddr = off[7:2];
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    #0.1;
    ->mon_ev;
    #0.1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] data);
    bus_we    = 1'b1;
    bus_waddr = off[7:2];
    bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic msp();
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic secp();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      n_errors++;
      $display("FAIL scoreboard: %0d reads left, expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_errors++;
      $display("FAIL watchdog: run not finished, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0;
    sec_tick = 1'b0; ms_tick = 1'b0; xtal_32000_in = 1'b1; xtal_32768_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    exp_rd(8'h00, 32'h0, "R1 ctrl");
    exp_rd(8'h10, stat_exp(8'h00, 1, 0), "R1 stat");
    exp_rd(8'h30, 32'h0, "R1 seconds");
    chk(alarm_irq, 1'b0, "R1 alarm_irq");

    // R2 aliases on CTRL
    wr(8'h00, 32'hFFFF_FFFF); exp_rd(8'h00, 32'h17, "R2 ctrl mask");
    wr(8'h00, 32'h13);        exp_rd(8'h00, 32'h13, "R2 plain write");
    wr(8'h04, 32'h04);        exp_rd(8'h00, 32'h17, "R2 set alias");
    wr(8'h08, 32'h03);        exp_rd(8'h00, 32'h14, "R2 clear alias");
    wr(8'h0C, 32'h11);        exp_rd(8'h00, 32'h05, "R2 toggle alias");
    wr(8'h00, 32'h0);

    // R3/R4/R6 lone seconds write: takes effect COPY_CYCLES+1 cycles later
    wr(8'h30, 32'd100);
    exp_rd(8'h10, stat_exp(8'h80, 1, 0), "R3 seconds stale");
    exp_rd(8'h30, 32'd0, "R6 seconds not yet copied");
    idle(4);
    exp_rd(8'h10, stat_exp(8'h80, 1, 0), "R4 stale before completion");
    idle(1);
    exp_rd(8'h10, stat_exp(8'h00, 1, 0), "R4 stale cleared");
    exp_rd(8'h30, 32'd100, "R6 seconds copied");

    // R4 order: PERS0 then PERS1 then ALARM, regardless of arrival
    wr(8'h30, 32'd200);
    wr(8'h40, 32'd205);
    wr(8'h70, 32'h1);
    wr(8'h60, 32'h5);
    exp_rd(8'h10, stat_exp(8'hC3, 1, 0), "R3 four stale");
    idle(2);
    exp_rd(8'h10, stat_exp(8'h43, 1, 0), "R4 seconds done first");
    idle(5);
    exp_rd(8'h10, stat_exp(8'h42, 1, 0), "R4 pers0 next");
    idle(5);
    exp_rd(8'h10, stat_exp(8'h40, 1, 0), "R4 pers1 next");
    idle(5);
    exp_rd(8'h10, stat_exp(8'h00, 1, 0), "R4 alarm last");
    exp_rd(8'h40, 32'd205, "R2 alarm value");

    // R5 restart of the running copy
    wr(8'h30, 32'd300);
    idle(1);
    wr(8'h30, 32'd310);
    idle(3);
    exp_rd(8'h10, stat_exp(8'h80, 1, 0), "R5 restarted copy still stale");
    idle(1);
    exp_rd(8'h10, stat_exp(8'h00, 1, 0), "R5 restarted copy done");
    exp_rd(8'h30, 32'd310, "R5 latest seconds value");

    // R6/R7/R8 alarm approach
    wr(8'h04, 32'h1);
    wr(8'h30, 32'd203);
    wr(8'h64, 32'h2);
    idle(12);
    exp_rd(8'h10, stat_exp(8'h00, 1, 0), "R4 copies settled");
    exp_rd(8'h60, 32'h07, "R2 pers0 set alias");
    exp_rd(8'h30, 32'd203, "R6 seconds reload");
    secp();
    exp_rd(8'h30, 32'd204, "R6 tick increments");
    chk(alarm_irq, 1'b0, "R7 no alarm before match");
    secp();
    idle(1);
    chk(alarm_irq, 1'b1, "R7 alarm_irq on match");
    exp_rd(8'h00, 32'h05, "R7 ctrl flag set");
    exp_rd(8'h60, 32'h87, "R8 wake flag set");
    wr(8'h08, 32'h4);
    chk(alarm_irq, 1'b0, "R7 cleared by alias");
    idle(2);
    chk(alarm_irq, 1'b0, "R7 no re-trigger on held match");
    exp_rd(8'h00, 32'h01, "R7 ctrl after clear");

    // R9 millisecond interrupt gating
    wr(8'h04, 32'h2);
    ms_tick = 1'b1; #0.1;
    chk(ms_irq, 1'b1, "R9 ms_irq enabled");
    wr(8'h08, 32'h2);
    #0.1;
    chk(ms_irq, 1'b0, "R9 ms_irq disabled");
    ms_tick = 1'b0;

    // R10 watchdog
    wr(8'h50, 32'd3);
    wr(8'h04, 32'h10);
    exp_rd(8'h50, 32'd3, "R10 timeout value");
    msp(); chk(wdog_rst, 1'b0, "R10 tick1");
    msp(); chk(wdog_rst, 1'b0, "R10 tick2");
    msp(); chk(wdog_rst, 1'b1, "R10 pulse on tick3");
    idle(1); chk(wdog_rst, 1'b0, "R10 pulse one cycle");
    msp(); msp(); chk(wdog_rst, 1'b0, "R10 reloaded count");
    msp(); chk(wdog_rst, 1'b1, "R10 second pulse");
    wr(8'h50, 32'd0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 4; i++) begin
        msp();
        if (wdog_rst) seen = 1'b1;
      end
      chk(seen, 1'b0, "R10 zero timeout disables");
    end
    wr(8'h08, 32'h10);

    // R11 force update marks all persistent copies stale
    wr(8'h74, 32'h8000_0000);
    exp_rd(8'h10, stat_exp(8'h03, 1, 0), "R11 all persistent stale");
    idle(12);
    exp_rd(8'h10, stat_exp(8'h00, 1, 0), "R11 copies done");
    exp_rd(8'h70, 32'h8000_0001, "R11 pers1 value");

    // R12 read-only and unmapped
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    exp_rd(8'h10, stat_exp(8'h00, 1, 0), "R12 stat unchanged");
    exp_rd(8'h20, 32'h0, "R12 unmapped reads 0");
    exp_rd(8'h00, 32'h01, "R12 ctrl untouched");
    xtal_32768_in = 1'b1; xtal_32000_in = 1'b0;
    exp_rd(8'h10, stat_exp(8'h00, 0, 1), "R1 crystal inputs mirrored");

    idle(2);
    finished = 1'b1;
    finish_run();
  end
endmodule